// File: doc/BRIEF.md
# Dithered PWM Tuning DAC

This block turns a tuning code into a single pulse-width-modulated pin that feeds an external low-pass filter. The code is wider than the pulse-width counter. The upper bits of the code set a base pulse width. The lower fraction bits choose how many periods, in each group of consecutive periods, carry one extra count of width. After filtering, the average level therefore moves by one fraction step for each code step. With the default sizes, a 10-bit modulator gives 14-bit resolution over groups of 16 periods.

The code changes through a valid/ready command port. A command can load an absolute code, move the code by a fine step (one fraction count) or a coarse step (one base-width count), or leave the code as it is. Step commands ask to raise or lower the oscillator frequency. A slope-sign input sets whether raising the frequency raises or lowers the code. Steps that would leave the code range are clamped, and a rail flag reports the clamp. An accepted code goes into use only at the next group boundary, so every group is built from a single code.

Top module: `dpwm_dac`

## Requirements
- R1: While reset is high and after it, before any command, pwm_o is low during reset, cmd_ready_o is high, both rail flags are low, and the active code is INIT_CODE (half of full scale by default).
- R2: Let P = 2^BASE_W, G = 2^FRAC_W, base = code[CODE_W-1:FRAC_W] and frac = code[FRAC_W-1:0]. Period p (0..G-1) of a group is high for base+1 cycles when the FRAC_W-bit reversal of p is less than frac, and for base cycles otherwise. So exactly frac of the G periods are extended.
- R3: A period whose width would be base+1 = P is high for all P cycles.
- R4: Code 0 keeps pwm_o low for whole groups.
- R5: A command is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both high. cmd_ready_o is then low until the last edge of the current group. At that edge the new code becomes active, and it first shapes period 0 of the next group.
- R6: Op 0 (load) sets the code to cmd_code_i and clears both rail flags.
- R7: Op 1 (fine) moves the code by 1 and op 2 (coarse) moves it by G. The move is upward when cmd_up_i XOR slope_neg_i is 1 and downward otherwise.
- R8: An upward step that would pass 2^CODE_W-1 gives 2^CODE_W-1 and sets rail_hi_o. Any accepted command that does not clamp at the top clears rail_hi_o. The two rail flags are never high together.
- R9: A downward step that would go below 0 gives 0 and sets rail_lo_o. Any accepted command that does not clamp at the bottom clears rail_lo_o.
- R10: Op 3 (keep) leaves the code unchanged and clears both rail flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | No code waiting for a group boundary |
| cmd_op_i | input | 2 | 0 load, 1 fine step, 2 coarse step, 3 keep |
| cmd_up_i | input | 1 | Step asks for a higher oscillator frequency |
| cmd_code_i | input | BASE_W+FRAC_W | Absolute code for load |
| slope_neg_i | input | 1 | Oscillator tunes down as its control rises |
| pwm_o | output | 1 | Registered dithered PWM output |
| rail_lo_o | output | 1 | Last command clamped at code 0 |
| rail_hi_o | output | 1 | Last command clamped at full scale |

## Verification
The testbench uses a 4-bit base and a 2-bit fraction. It loads every one of the 64 codes and counts high cycles in each period. This sweep separates a wrong base width, a wrong count of extended periods, and a wrong placement of extended periods in the reversed-index order. It also covers the all-low code and the all-high periods. Fine and coarse steps are issued in both directions under both slope signs, which shows whether the direction is inverted and whether the step size is right. Steps into both rails, followed by steps and keep commands away from them, show the clamp value and when each flag is set and cleared. Ready and the flags are compared every cycle against a model that applies codes only at group ends.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_FINE   = 2'd1,
    OP_COARSE = 2'd2,
    OP_KEEP   = 2'd3
  } dpwm_op_e;
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int BASE_W = 10,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [BASE_W-1:0] cnt_o,
  output logic [FRAC_W-1:0] grp_o,
  output logic              grp_end_o
);
  // count within a period, and period index within a group
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      grp_o <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
      if (&cnt_o) grp_o <= grp_o + 1'b1;
    end
  end

  assign grp_end_o = (&cnt_o) & (&grp_o);
endmodule

// File: rtl/dpwm_code_ctrl.sv
module dpwm_code_ctrl
  import dpwm_pkg::*;
#(
  parameter int CODE_W    = 14,
  parameter int FRAC_W    = 4,
  parameter int INIT_CODE = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_up_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              slope_neg_i,
  input  logic              grp_end_i,
  output logic [CODE_W-1:0] act_code_o,
  output logic [CODE_W-1:0] pend_code_o,
  output logic              rail_lo_o,
  output logic              rail_hi_o
);
  localparam logic [CODE_W:0] CODE_MAX = {1'b0, {CODE_W{1'b1}}};
  localparam logic [CODE_W:0] STEP_C   = (CODE_W+1)'(1) << FRAC_W;
  localparam logic [CODE_W:0] STEP_F   = (CODE_W+1)'(1);

  dpwm_op_e        op;
  logic            pend;
  logic            accept;
  logic            raise;
  logic [CODE_W:0] step;
  logic [CODE_W:0] wide;
  logic [CODE_W:0] up_sum;
  logic [CODE_W-1:0] nxt_code;
  logic            nxt_lo;
  logic            nxt_hi;

  assign op          = dpwm_op_e'(cmd_op_i);
  assign cmd_ready_o = ~pend;
  assign accept      = cmd_valid_i & ~pend;
  assign raise       = cmd_up_i ^ slope_neg_i;
  assign step        = (op == OP_COARSE) ? STEP_C : STEP_F;
  assign wide        = {1'b0, act_code_o};
  assign up_sum      = wide + step;

  always_comb begin
    nxt_code = act_code_o;
    nxt_lo   = 1'b0;
    nxt_hi   = 1'b0;
    case (op)
      OP_LOAD: nxt_code = cmd_code_i;
      OP_KEEP: nxt_code = act_code_o;
      default: begin
        if (raise) begin
          if (up_sum > CODE_MAX) begin
            nxt_code = CODE_MAX[CODE_W-1:0];
            nxt_hi   = 1'b1;
          end else begin
            nxt_code = up_sum[CODE_W-1:0];
          end
        end else begin
          if (wide < step) begin
            nxt_code = '0;
            nxt_lo   = 1'b1;
          end else begin
            nxt_code = act_code_o - step[CODE_W-1:0];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      act_code_o  <= CODE_W'(INIT_CODE);
      pend_code_o <= CODE_W'(INIT_CODE);
      rail_lo_o   <= 1'b0;
      rail_hi_o   <= 1'b0;
    end else begin
      if (pend && grp_end_i) begin
        act_code_o <= pend_code_o;
        pend       <= 1'b0;
      end
      if (accept) begin
        pend        <= 1'b1;
        pend_code_o <= nxt_code;
        rail_lo_o   <= nxt_lo;
        rail_hi_o   <= nxt_hi;
      end
    end
  end
endmodule

// File: rtl/dpwm_modulator.sv
module dpwm_modulator #(
  parameter int BASE_W = 10,
  parameter int FRAC_W = 4,
  localparam int CODE_W = BASE_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BASE_W-1:0] cnt_i,
  input  logic [FRAC_W-1:0] grp_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pwm_o
);
  logic [FRAC_W-1:0] grp_rev;
  logic [FRAC_W-1:0] frac;
  logic [BASE_W:0]   width;
  logic              ext;

  // reversed period index spreads extended periods over the group
  for (genvar i = 0; i < FRAC_W; i++) begin : g_rev
    assign grp_rev[i] = grp_i[FRAC_W-1-i];
  end

  assign frac  = code_i[FRAC_W-1:0];
  assign ext   = grp_rev < frac;
  assign width = {1'b0, code_i[CODE_W-1:FRAC_W]} + {{BASE_W{1'b0}}, ext};

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= {1'b0, cnt_i} < width;
  end
endmodule

// File: rtl/dpwm_dac.sv
module dpwm_dac #(
  parameter int BASE_W    = 10,
  parameter int FRAC_W    = 4,
  parameter int INIT_CODE = 1 << (BASE_W + FRAC_W - 1),
  localparam int CODE_W   = BASE_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_up_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              slope_neg_i,
  output logic              pwm_o,
  output logic              rail_lo_o,
  output logic              rail_hi_o
);
  logic [BASE_W-1:0] cnt_val;
  logic [FRAC_W-1:0] grp_idx;
  logic              grp_end;
  logic [CODE_W-1:0] act_code;
  logic [CODE_W-1:0] pend_code;

  dpwm_timebase #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) tb_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_o     (cnt_val),
    .grp_o     (grp_idx),
    .grp_end_o (grp_end)
  );

  dpwm_code_ctrl #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .INIT_CODE(INIT_CODE)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_op_i    (cmd_op_i),
    .cmd_up_i    (cmd_up_i),
    .cmd_code_i  (cmd_code_i),
    .slope_neg_i (slope_neg_i),
    .grp_end_i   (grp_end),
    .act_code_o  (act_code),
    .pend_code_o (pend_code),
    .rail_lo_o   (rail_lo_o),
    .rail_hi_o   (rail_hi_o)
  );

  dpwm_modulator #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) mod_i (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (cnt_val),
    .grp_i  (grp_idx),
    .code_i (act_code),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/dpwm_dac_chk.sv
module dpwm_dac_chk #(
  parameter int BASE_W = 10,
  parameter int FRAC_W = 4,
  localparam int CODE_W = BASE_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [1:0]        cmd_op_i,
  input logic              cmd_up_i,
  input logic              slope_neg_i,
  input logic              pwm_o,
  input logic              rail_lo_o,
  input logic              rail_hi_o,
  input logic [FRAC_W-1:0] grp_idx,
  input logic              grp_end,
  input logic [CODE_W-1:0] act_code,
  input logic [CODE_W-1:0] pend_code
);
  localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

  logic acc;
  logic is_step;
  logic up_dir;
  assign acc     = cmd_valid_i & cmd_ready_o;
  assign is_step = (cmd_op_i == 2'd1) || (cmd_op_i == 2'd2);
  assign up_dir  = cmd_up_i ^ slope_neg_i;

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> !cmd_ready_o);

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !grp_end |=> $stable(act_code));

  // R4
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_code == '0) |=> !pwm_o);

  // R3
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((&act_code[CODE_W-1:FRAC_W]) && (act_code[FRAC_W-1:0] != '0) && (grp_idx == '0)) |=> pwm_o);

  // R7
  fine_up_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op_i == 2'd1 && up_dir && act_code != CMAX) |=> (pend_code == CODE_W'($past(act_code) + 1'b1)));

  // R8
  top_rail_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && is_step && up_dir && act_code == CMAX) |=> rail_hi_o);

  // R9
  bottom_rail_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && is_step && !up_dir && act_code == '0) |=> rail_lo_o);

  // R8
  rail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rail_lo_o && rail_hi_o));
endmodule

bind dpwm_dac dpwm_dac_chk #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .cmd_up_i    (cmd_up_i),
  .slope_neg_i (slope_neg_i),
  .pwm_o       (pwm_o),
  .rail_lo_o   (rail_lo_o),
  .rail_hi_o   (rail_hi_o),
  .grp_idx     (grp_idx),
  .grp_end     (grp_end),
  .act_code    (act_code),
  .pend_code   (pend_code)
);

// File: tb/dpwm_dac_tb_top.sv
module dpwm_dac_tb_top;
  localparam int BW   = 4;
  localparam int FW   = 2;
  localparam int CW   = BW + FW;
  localparam int P    = 1 << BW;
  localparam int G    = 1 << FW;
  localparam int PG   = P * G;
  localparam int CMAX = (1 << CW) - 1;
  localparam int INIT = 1 << (CW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic [1:0]    cmd_op_i = 2'd0;
  logic          cmd_up_i = 1'b0;
  logic [CW-1:0] cmd_code_i = '0;
  logic          slope_neg_i = 1'b0;
  logic          pwm_o;
  logic          rail_lo_o;
  logic          rail_hi_o;

  always #5 clk = ~clk;

  dpwm_dac #(.BASE_W(BW), .FRAC_W(FW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_op_i    (cmd_op_i),
    .cmd_up_i    (cmd_up_i),
    .cmd_code_i  (cmd_code_i),
    .slope_neg_i (slope_neg_i),
    .pwm_o       (pwm_o),
    .rail_lo_o   (rail_lo_o),
    .rail_hi_o   (rail_hi_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    ncyc = 0;
  int    hi_acc = 0;
  int    cur_code = INIT;
  int    pend_m = INIT;
  bit    m_pend = 0;
  bit    m_lo = 0;
  bit    m_hi = 0;
  bit    done = 0;
  string src_tag = "R1";
  string pend_tag = "R6";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int bitrev(input int v);
    int r = 0;
    for (int i = 0; i < FW; i++) if (v[i]) r |= 1 << (FW - 1 - i);
    return r;
  endfunction

  function automatic int exp_high(input int code, input int p);
    int base = code >> FW;
    int frac = code % G;
    return base + ((bitrev(p) < frac) ? 1 : 0);
  endfunction

  // cycle monitor: period widths, ready and rail flags against the model
  always @(negedge clk) begin : mon
    int j, p, ex, nc, stp;
    bit up, lo, hi;
    string tg;
    if (rst) begin
      ncyc = 0; hi_acc = 0; cur_code = INIT; m_pend = 0;
      m_lo = 0; m_hi = 0; src_tag = "R1";
    end else begin
      ncyc++;
      hi_acc += int'(pwm_o);
      if (ncyc % P == 0) begin
        j  = (ncyc - 1) / P;
        p  = j % G;
        ex = exp_high(cur_code, p);
        tg = (cur_code == 0) ? "R4" : ((ex == P) ? "R3" : "R2");
        check(hi_acc == ex, {tg, " period width, code from ", src_tag}, hi_acc, ex);
        hi_acc = 0;
      end
      if ((ncyc % PG == 0) && m_pend) begin
        cur_code = pend_m;
        m_pend   = 0;
        src_tag  = pend_tag;
      end
      check(cmd_ready_o == !m_pend, "R5 ready", int'(cmd_ready_o), int'(!m_pend));
      check(rail_hi_o == m_hi, "R8 top rail flag", int'(rail_hi_o), int'(m_hi));
      check(rail_lo_o == m_lo, "R9 bottom rail flag", int'(rail_lo_o), int'(m_lo));
      if (cmd_valid_i && cmd_ready_o) begin
        lo = 0; hi = 0; nc = cur_code;
        up = cmd_up_i ^ slope_neg_i;
        stp = (cmd_op_i == 2'd2) ? G : 1;
        case (cmd_op_i)
          2'd0: begin nc = int'(cmd_code_i); pend_tag = "R6"; end
          2'd3: begin nc = cur_code; pend_tag = "R10"; end
          default: begin
            pend_tag = "R7";
            if (up) begin
              nc = cur_code + stp;
              if (nc > CMAX) begin nc = CMAX; hi = 1; end
            end else begin
              nc = cur_code - stp;
              if (nc < 0) begin nc = 0; lo = 1; end
            end
          end
        endcase
        pend_m = nc; m_pend = 1; m_lo = lo; m_hi = hi;
      end
    end
  end

  task automatic send(input int op, input bit up, input int code, input bit sneg);
    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid_i = 1'b1; cmd_op_i = 2'(op); cmd_up_i = up;
    cmd_code_i = CW'(code); slope_neg_i = sneg;
    @(posedge clk); #1;
    cmd_valid_i = 1'b0;
    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    repeat (PG) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
    check(cmd_ready_o == 1'b1, "R1 ready in reset", int'(cmd_ready_o), 1);
    check(rail_lo_o == 1'b0 && rail_hi_o == 1'b0, "R1 flags in reset",
          int'({rail_hi_o, rail_lo_o}), 0);
    #1 rst = 1'b0;
    repeat (2 * PG) @(negedge clk);
    // R6 exhaustive load sweep, covers R2 R3 R4
    for (int c = 0; c <= CMAX; c++) send(0, 1'b0, c, 1'b0);
    // R7 steps, positive slope
    send(0, 1'b0, 30, 1'b0);
    send(1, 1'b1, 0, 1'b0);
    send(2, 1'b1, 0, 1'b0);
    send(1, 1'b0, 0, 1'b0);
    send(2, 1'b0, 0, 1'b0);
    // R7 steps, negative slope
    send(1, 1'b1, 0, 1'b1);
    send(2, 1'b1, 0, 1'b1);
    send(1, 1'b0, 0, 1'b1);
    send(2, 1'b0, 0, 1'b1);
    // R8 top rail and release
    send(0, 1'b0, CMAX - 2, 1'b0);
    send(2, 1'b1, 0, 1'b0);
    send(1, 1'b1, 0, 1'b0);
    send(1, 1'b0, 0, 1'b1);
    send(1, 1'b0, 0, 1'b0);
    // R9 bottom rail and release
    send(0, 1'b0, 2, 1'b0);
    send(2, 1'b0, 0, 1'b0);
    send(1, 1'b0, 0, 1'b0);
    send(1, 1'b1, 0, 1'b1);
    send(1, 1'b1, 0, 1'b0);
    // R10 keep clears a flag and holds the code
    send(1, 1'b0, 0, 1'b0);
    send(1, 1'b0, 0, 1'b0);
    send(3, 1'b0, 0, 1'b0);
    send(0, 1'b0, CMAX, 1'b0);
    send(1, 1'b1, 0, 1'b0);
    send(3, 1'b1, 0, 1'b0);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      finish_run();
    end
  end
endmodule